// File: doc/BRIEF.md
# Programmable I2C Bit Timing Generator

This block produces the SCL waveform and two SDA strobes for an I2C master. It takes one 32-bit timing word that holds a prescaler, separate SCL low and high counts, an SDA hold delay and an SCL setup delay. It drives SCL low through an open-drain style `scl_low` output. It raises `sda_change` at the moment the transfer controller may move SDA, and `sda_sample` at the moment it should read SDA.

Once enabled, the block runs back-to-back bit periods. Each period has a low phase and a released phase. The released phase turns into a counted high phase only when SCL is actually seen high, so a target that holds the line low stretches the clock. The timing word is captured only while the block is disabled. Byte framing, START/STOP and acknowledge handling belong to the transfer controller. `scl_stretch` is expected to be synchronous to `clk`.

Top module: `i2c_bit_timer`

## Requirements
- R1: While `en` is low, and in the cycle after reset, `scl_low`, `sda_change` and `sda_sample` are all 0. The low phase of the first bit starts at the first clock edge that samples `en` high.
- R2: Every phase count is measured in ticks of P = PRESC+1 clock cycles, where PRESC is `timing_word[31:28]`.
- R3: Each low phase keeps `scl_low` at 1 for exactly max(SCLL+1, SDADEL+SCLDEL+2)·P cycles, where SCLL is `timing_word[7:0]`.
- R4: `sda_change` pulses for exactly one cycle in each low phase, (SDADEL+1)·P−1 cycles after the first low cycle, where SDADEL is `timing_word[19:16]`.
- R5: SCL is not released until SCLDEL+1 ticks after the SDA change tick, where SCLDEL is `timing_word[23:20]`. When this delay is larger than the SCLL count, it sets the low phase length.
- R6: After the release, one cycle is spent observing the line. The high count of (SCLH+1)·P cycles follows, where SCLH is `timing_word[15:8]`, so the released time is (SCLH+1)·P+1 cycles.
- R7: While `scl_stretch` is 1 in the observation state, the block stays released and the high count does not start. Each such cycle lengthens the released time by one cycle.
- R8: `sda_sample` pulses for exactly one cycle per high phase, (floor(SCLH/2)+1)·P cycles after the first released cycle.
- R9: Changes to `timing_word` while `en` is high have no effect. The value present at the last clock edge with `en` low is the one used after enabling.
- R10: `sda_change` and `sda_sample` are never high together. `sda_change` occurs only while `scl_low` is 1, and `sda_sample` only while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run bit periods; low forces idle and opens the timing word capture |
| timing_word | input | 32 | Prescaler, SCL low/high counts, SDA hold and SCL setup delays |
| scl_stretch | input | 1 | 1 when SCL is seen low although this block releases it |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_change | output | 1 | One-cycle strobe: SDA may change now |
| sda_sample | output | 1 | One-cycle strobe: sample SDA now |

## Verification
A wrong phase state or a bad tick count shows up within a single bit period as a mis-sized low or released interval, measured in cycles at `scl_low`. A strobe sitting at the wrong tick shows up in the same way, and so does a strobe that is missing or doubled. A timing word leaking through while enabled changes the very next period, so the bench changes the word while enabled and measures the next period. A block that ignores the stretch input shows up as a released interval that does not grow, and so does an idle state that leaks pulses.

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] timing_word,
  input  logic          scl_stretch,
  output logic          scl_low,
  output logic          sda_change,
  output logic          sda_sample
);
  localparam int CW = 9;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_WAIT, PH_HIGH} ph_t;

  logic [TW-1:0] cfg;
  ph_t           ph;
  logic [3:0]    pc;
  logic [CW-1:0] tc;

  logic       unused_rsvd;
  assign unused_rsvd = ^cfg[27:24];

  wire [3:0]    presc   = cfg[31:28];
  wire [CW-1:0] lo_cnt  = {1'b0, cfg[7:0]} + 9'd1;
  wire [CW-1:0] dly_cnt = {5'd0, cfg[19:16]} + {5'd0, cfg[23:20]} + 9'd2;
  wire [CW-1:0] low_len = (lo_cnt > dly_cnt) ? lo_cnt : dly_cnt;
  wire [CW-1:0] hi_len  = {1'b0, cfg[15:8]} + 9'd1;
  wire [CW-1:0] mid     = {2'b0, cfg[15:9]} + 9'd1;
  wire [CW-1:0] tc_nx   = tc + 9'd1;
  wire          tick    = (pc == presc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
      ph  <= PH_IDLE;
      pc  <= '0;
      tc  <= '0;
    end else if (!en) begin
      cfg <= timing_word;
      ph  <= PH_IDLE;
      pc  <= '0;
      tc  <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          ph <= PH_LOW;
          pc <= '0;
          tc <= '0;
        end
        PH_LOW: begin
          if (tick) begin
            pc <= '0;
            if (tc_nx == low_len) begin
              ph <= PH_WAIT;
              tc <= '0;
            end else begin
              tc <= tc_nx;
            end
          end else begin
            pc <= pc + 4'd1;
          end
        end
        PH_WAIT: begin
          if (!scl_stretch) ph <= PH_HIGH;
        end
        PH_HIGH: begin
          if (tick) begin
            pc <= '0;
            if (tc_nx == hi_len) begin
              ph <= PH_LOW;
              tc <= '0;
            end else begin
              tc <= tc_nx;
            end
          end else begin
            pc <= pc + 4'd1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign scl_low    = (ph == PH_LOW);
  assign sda_change = (ph == PH_LOW)  && tick && (tc == {5'd0, cfg[19:16]});
  assign sda_sample = (ph == PH_HIGH) && tick && (tc_nx == mid);

endmodule

module i2c_bit_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        scl_stretch,
  input logic        scl_low,
  input logic        sda_change,
  input logic        sda_sample,
  input logic        in_wait,
  input logic [31:0] cfg
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> (!scl_low && !sda_change && !sda_sample));

  assert_change_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change |-> scl_low);

  assert_stretch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_wait && scl_stretch) |=> (!scl_low && in_wait));

  assert_sample_in_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample |-> !scl_low);

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(cfg));

  assert_strobes_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_change && sda_sample));
endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .scl_stretch (scl_stretch),
  .scl_low     (scl_low),
  .sda_change  (sda_change),
  .sda_sample  (sda_sample),
  .in_wait     (ph == PH_WAIT),
  .cfg         (cfg)
);

// File: tb/test_i2c_bit_timer.sv
module test_i2c_bit_timer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic [31:0] timing_word = '0;
  logic        scl_stretch = 0;
  logic        scl_low, sda_change, sda_sample;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  i2c_bit_timer i_i2c_bit_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .timing_word(timing_word),
    .scl_stretch(scl_stretch), .scl_low(scl_low),
    .sda_change(sda_change), .sda_sample(sda_sample)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int presc, input int sclldel,
                                       input int sdadel, input int sclh, input int scll);
    return {presc[3:0], 4'h0, sclldel[3:0], sdadel[3:0], sclh[7:0], scll[7:0]};
  endfunction

  // Measures one full bit period starting at the next low phase.
  task automatic measure(input int nstr, output int lo, output int chg, output int nchg,
                         output int hi, output int smp, output int nsmp);
    logic prev;
    int guard;
    prev = scl_low; lo = 0; hi = 0; chg = -1; smp = -1; nchg = 0; nsmp = 0; guard = 0;
    forever begin
      @(negedge clk);
      if (scl_low && !prev) break;
      prev = scl_low;
      guard++;
      if (guard > 5000) return;
    end
    while (scl_low && guard < 5000) begin
      if (sda_change) begin chg = lo; nchg++; end
      if (sda_sample) nsmp++;
      lo++; guard++;
      @(negedge clk);
    end
    while (!scl_low && guard < 5000) begin
      scl_stretch = (hi < nstr);
      if (sda_sample) begin smp = hi; nsmp++; end
      if (sda_change) nchg++;
      hi++; guard++;
      @(negedge clk);
    end
    scl_stretch = 0;
  endtask

  task automatic start(input logic [31:0] w);
    en = 0;
    timing_word = w;
    repeat (3) @(negedge clk);
    en = 1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset scl_low", scl_low, 0);
    chk("R1 reset change", sda_change, 0);
    chk("R1 reset sample", sda_sample, 0);
  endtask

  task automatic t_basic;
    int lo, chg, nchg, hi, smp, nsmp;
    start(word(0, 1, 1, 3, 5));
    measure(0, lo, chg, nchg, hi, smp, nsmp);
    chk("R3 low len basic", lo, 6);
    chk("R4 change pos basic", chg, 1);
    chk("R4 change count", nchg, 1);
    chk("R6 released len basic", hi, 5);
    chk("R8 sample pos basic", smp, 2);
    chk("R8 sample count", nsmp, 1);
  endtask

  task automatic t_presc;
    int lo, chg, nchg, hi, smp, nsmp;
    start(word(2, 0, 0, 4, 3));
    measure(0, lo, chg, nchg, hi, smp, nsmp);
    chk("R2 R3 low len presc", lo, 12);
    chk("R2 R4 change pos presc", chg, 2);
    chk("R2 R6 released len presc", hi, 16);
    chk("R2 R8 sample pos presc", smp, 9);
  endtask

  task automatic t_delay;
    int lo, chg, nchg, hi, smp, nsmp;
    start(word(0, 5, 4, 0, 1));
    measure(0, lo, chg, nchg, hi, smp, nsmp);
    chk("R5 low len set by delays", lo, 11);
    chk("R4 change pos delay", chg, 4);
    chk("R6 released len min", hi, 2);
    chk("R8 sample pos min", smp, 1);
    chk("R10 sample once", nsmp, 1);
  endtask

  task automatic t_stretch;
    int lo, chg, nchg, hi, smp, nsmp;
    start(word(0, 1, 1, 3, 5));
    measure(7, lo, chg, nchg, hi, smp, nsmp);
    chk("R7 released len stretched", hi, 12);
    chk("R7 sample pos stretched", smp, 9);
    chk("R7 low len unchanged", lo, 6);
  endtask

  task automatic t_cfg_freeze;
    int lo, chg, nchg, hi, smp, nsmp;
    start(word(0, 1, 1, 3, 5));
    @(negedge clk);
    timing_word = word(2, 0, 0, 4, 3);
    measure(0, lo, chg, nchg, hi, smp, nsmp);
    chk("R9 low len frozen", lo, 6);
    chk("R9 released len frozen", hi, 5);
    en = 0;
    repeat (2) @(negedge clk);
    en = 1;
    measure(0, lo, chg, nchg, hi, smp, nsmp);
    chk("R9 low len after reload", lo, 12);
    chk("R9 released len after reload", hi, 16);
  endtask

  task automatic t_disable;
    int bad;
    start(word(0, 1, 1, 3, 5));
    repeat (4) @(negedge clk);
    en = 0;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      if (scl_low || sda_change || sda_sample) bad++;
      @(negedge clk);
    end
    chk("R1 idle while disabled", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_basic();
    t_presc();
    t_delay();
    t_stretch();
    t_cfg_freeze();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule